// File: doc/BRIEF.md
# Transmit Bit Gearbox, Variable Blocks to 32-Bit Words

This block sits between a 128b/130b block source and a serializer that takes a fixed 32-bit word per clock. Each input block begins with its two sync header bits and continues with payload. A length code comes with each block. It selects either the normal 130-bit block or one of the skip ordered-set lengths: 66, 98, 130, 162 or 194 bits. The block packs these bits back to back into 32-bit output words, with no idle bits between blocks.

Block lengths are not multiples of 32, so leftover bits stay in a residue store and are sent in front of the next block. The source sees a ready/valid handshake. Ready is withdrawn while the store already holds enough bits for the next output words, and the source is stalled for that time. A block with an unknown length code is taken off the input, discarded, and reported with a one-cycle error pulse. The bit alignment of the stream does not change.

Top module: `gbx_tx_130_32`

## Requirements
- R1: The length code `in_len` maps values 0, 1, 2, 3, 4 to block lengths of 66, 98, 130, 162 and 194 bits. Code 2 is also the normal 130-bit block. Codes 5, 6 and 7 are illegal.
- R2: Bit 0 of `in_data` is sent first, so the two sync header bits `in_data[1:0]` lead their block and pass unchanged. Within each output word, bit 0 is the earliest bit. Consecutive blocks are joined with no gap. Bits of `in_data` at or above the block length never reach the output.
- R3: The residue never exceeds 226 bits. `in_ready` is 1 exactly when fewer than 64 bits are held.
- R4: If the store holds at least 32 bits at a clock edge, then after that edge `out_valid` is 1 and `out_data` carries the next 32 bits. Otherwise, after that edge `out_valid` is 0 and `out_data` is zero. A block accepted into an empty store appears at the output one cycle after its accepting edge.
- R5: Sixteen 130-bit blocks offered back to back into an empty store come out as exactly 65 valid words in 65 consecutive cycles, with nothing left over.
- R6: A block with an illegal code still completes the handshake and is dropped. `len_err` is 1 for the one cycle after its accepting edge and is 0 otherwise. The bits around the dropped block stay contiguous.
- R7: While reset is held, and after it is released, `out_data` is 0, `out_valid` is 0, `len_err` is 0 and `in_ready` is 1. Any residue held before the reset is discarded.
- R8: Every legal length is accepted in any order or mix, and the stream stays bit-exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source presents a block |
| in_ready | output | 1 | Gearbox takes the block at this edge |
| in_len | input | 3 | Block length code |
| in_data | input | 194 | Block bits, sync header in bits 1:0, sent LSB first |
| out_data | output | 32 | Word for the serializer, bit 0 earliest |
| out_valid | output | 1 | Word carries stream bits |
| len_err | output | 1 | Pulse: illegal length code dropped |

## Verification
A wrong residue count or a wrong shift shows at the ports as a corrupted word. It appears on the first output word that contains the affected bits, usually one or two cycles after the faulty accept. The bench compares every word bit by bit against a bit-queue model of the stream, so one slipped bit is caught. A wrong count also shifts `in_ready` and `out_valid` away from the model's threshold in the same cycle. These are checked every cycle together with the timing of `len_err`.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
    localparam int GBX_OUT_W     = 32;
    localparam int GBX_MIN_BLK   = 66;
    localparam int GBX_BLK_STEP  = 32;
    localparam int GBX_NUM_CODES = 5;
    localparam int GBX_CODE_W    = 3;
    localparam int GBX_MAX_BLK   = GBX_MIN_BLK + GBX_BLK_STEP * (GBX_NUM_CODES - 1);
endpackage

// File: rtl/gbx_len_dec.sv
module gbx_len_dec #(
    parameter int CODE_W    = 3,
    parameter int CNT_W     = 8,
    parameter int MIN_BLK   = 66,
    parameter int BLK_STEP  = 32,
    parameter int NUM_CODES = 5
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  blk_len,
    output logic              legal
);
    localparam logic [CNT_W-1:0] BASE_C = CNT_W'(MIN_BLK);
    localparam logic [CNT_W-1:0] STEP_C = CNT_W'(BLK_STEP);

    always_comb begin
        legal   = (code < CODE_W'(NUM_CODES));
        blk_len = BASE_C + CNT_W'(code) * STEP_C;
    end
endmodule

// File: rtl/gbx_blk_mask.sv
module gbx_blk_mask #(
    parameter int MAX_BLK = 194,
    parameter int CNT_W   = 8
) (
    input  logic [MAX_BLK-1:0] raw,
    input  logic [CNT_W-1:0]   blk_len,
    output logic [MAX_BLK-1:0] clean
);
    for (genvar i = 0; i < MAX_BLK; i++) begin : g_bit
        assign clean[i] = raw[i] & (blk_len > CNT_W'(i));
    end
endmodule

// File: rtl/gbx_pack_core.sv
module gbx_pack_core #(
    parameter int OUT_W   = 32,
    parameter int MAX_BLK = 194,
    parameter int HOLD_W  = OUT_W + MAX_BLK,
    parameter int CNT_W   = $clog2(HOLD_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               drop,
    input  logic [MAX_BLK-1:0] blk,
    input  logic [CNT_W-1:0]   blk_len,
    output logic [OUT_W-1:0]   word,
    output logic               word_vld,
    output logic               err,
    output logic               room,
    output logic [CNT_W-1:0]   held
);
    localparam logic [CNT_W-1:0] WORD_C = CNT_W'(OUT_W);
    localparam logic [CNT_W-1:0] ROOM_C = CNT_W'(2 * OUT_W);

    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic [CNT_W-1:0]  cnt;
        logic [OUT_W-1:0]  word;
        logic              vld;
        logic              err;
    } pack_st_t;

    pack_st_t st_d, st_q;

    logic              emit;
    logic [HOLD_W-1:0] rem_hold;
    logic [CNT_W-1:0]  rem_cnt;
    logic [HOLD_W-1:0] blk_ext;

    always_comb begin
        st_d     = st_q;
        emit     = (st_q.cnt >= WORD_C);
        rem_hold = emit ? (st_q.hold >> OUT_W) : st_q.hold;
        rem_cnt  = emit ? (st_q.cnt - WORD_C) : st_q.cnt;
        blk_ext  = {{(HOLD_W-MAX_BLK){1'b0}}, blk};

        st_d.word = emit ? st_q.hold[OUT_W-1:0] : '0;
        st_d.vld  = emit;
        st_d.err  = drop;
        if (push) begin
            st_d.hold = rem_hold | (blk_ext << rem_cnt);
            st_d.cnt  = rem_cnt + blk_len;
        end else begin
            st_d.hold = rem_hold;
            st_d.cnt  = rem_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word     = st_q.word;
    assign word_vld = st_q.vld;
    assign err      = st_q.err;
    assign held     = st_q.cnt;
    assign room     = (st_q.cnt < ROOM_C);
endmodule

// File: rtl/gbx_tx_130_32.sv
module gbx_tx_130_32 #(
    parameter int OUT_W     = gbx_pkg::GBX_OUT_W,
    parameter int MIN_BLK   = gbx_pkg::GBX_MIN_BLK,
    parameter int BLK_STEP  = gbx_pkg::GBX_BLK_STEP,
    parameter int NUM_CODES = gbx_pkg::GBX_NUM_CODES,
    parameter int CODE_W    = gbx_pkg::GBX_CODE_W,
    parameter int MAX_BLK   = MIN_BLK + BLK_STEP * (NUM_CODES - 1),
    parameter int HOLD_W    = OUT_W + MAX_BLK,
    parameter int CNT_W     = $clog2(HOLD_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [CODE_W-1:0]  in_len,
    input  logic [MAX_BLK-1:0] in_data,
    output logic [OUT_W-1:0]   out_data,
    output logic               out_valid,
    output logic               len_err
);
    logic [CNT_W-1:0]   blk_len;
    logic               legal;
    logic [MAX_BLK-1:0] blk_clean;
    logic               take;
    logic [CNT_W-1:0]   held_cnt;

    gbx_len_dec #(
        .CODE_W(CODE_W), .CNT_W(CNT_W), .MIN_BLK(MIN_BLK),
        .BLK_STEP(BLK_STEP), .NUM_CODES(NUM_CODES)
    ) u_dec (
        .code(in_len), .blk_len(blk_len), .legal(legal)
    );

    gbx_blk_mask #(.MAX_BLK(MAX_BLK), .CNT_W(CNT_W)) u_mask (
        .raw(in_data), .blk_len(blk_len), .clean(blk_clean)
    );

    assign take = in_valid & in_ready;

    gbx_pack_core #(
        .OUT_W(OUT_W), .MAX_BLK(MAX_BLK), .HOLD_W(HOLD_W), .CNT_W(CNT_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n),
        .push(take & legal), .drop(take & ~legal),
        .blk(blk_clean), .blk_len(blk_len),
        .word(out_data), .word_vld(out_valid), .err(len_err),
        .room(in_ready), .held(held_cnt)
    );
endmodule

// File: rtl/gbx_tx_chk.sv
module gbx_tx_chk #(
    parameter int OUT_W     = 32,
    parameter int HOLD_W    = 226,
    parameter int CNT_W     = 8,
    parameter int CODE_W    = 3,
    parameter int NUM_CODES = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [CODE_W-1:0] in_len,
    input logic [OUT_W-1:0]  out_data,
    input logic              out_valid,
    input logic              len_err,
    input logic [CNT_W-1:0]  held
);
    logic bad_take, good_take;
    assign bad_take  = in_valid && in_ready && (in_len >= CODE_W'(NUM_CODES));
    assign good_take = in_valid && in_ready && (in_len <  CODE_W'(NUM_CODES));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        held <= CNT_W'(HOLD_W)); // R3
    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (held >= CNT_W'(2 * OUT_W)) |-> !in_ready); // R3
    AST_EMIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (held >= CNT_W'(OUT_W)) |=> out_valid); // R4
    AST_HOLD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (held < CNT_W'(OUT_W)) |=> !out_valid); // R4
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0)); // R4
    AST_ERR_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        bad_take |=> len_err); // R6
    AST_QUIET_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (good_take || !in_valid) |=> !len_err); // R6
    AST_BAD_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_take && held < CNT_W'(OUT_W)) |=> $stable(held)); // R6
endmodule

bind gbx_tx_130_32 gbx_tx_chk #(
    .OUT_W(OUT_W), .HOLD_W(HOLD_W), .CNT_W(CNT_W),
    .CODE_W(CODE_W), .NUM_CODES(NUM_CODES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_len(in_len), .out_data(out_data), .out_valid(out_valid),
    .len_err(len_err), .held(held_cnt)
);

// File: tb/sim_gbx_tx_130_32.sv
`timescale 1ns/1ps
module sim_gbx_tx_130_32;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [2:0]   in_len;
    logic [193:0] in_data;
    logic [31:0]  out_data;
    logic         out_valid;
    logic         len_err;

    always #5 clk = ~clk;

    gbx_tx_130_32 u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_len(in_len), .in_data(in_data), .out_data(out_data),
        .out_valid(out_valid), .len_err(len_err)
    );

    int n_chk = 0;
    int n_err = 0;
    bit exp_q[$];
    logic [2:0]   code_q[$];
    logic [193:0] data_q[$];
    logic [31:0]  exp_word;
    bit exp_vld, exp_err;
    int nwords, cyc_n, first_v, last_v, nstall;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [193:0] rnd_blk();
        logic [223:0] w;
        for (int k = 0; k < 7; k++) w[k*32 +: 32] = $urandom;
        return w[193:0];
    endfunction

    function automatic int code_len(input logic [2:0] c);
        return 66 + 32 * int'(c);
    endfunction

    // one clock: sample at negedge, update the model, drive the next input
    task automatic cyc();
        @(negedge clk);
        cyc_n++;
        chk(out_valid == exp_vld, "R4 out_valid", out_valid, exp_vld);
        if (exp_vld) chk(out_data == exp_word, "R2 word bits", out_data, exp_word);
        else         chk(out_data == 32'd0, "R4 idle word zero", out_data, 0);
        chk(len_err == exp_err, "R6 len_err", len_err, exp_err);
        chk(in_ready == (exp_q.size() < 64), "R3 in_ready", in_ready, exp_q.size() < 64);
        if (out_valid) begin
            nwords++;
            if (first_v < 0) first_v = cyc_n;
            last_v = cyc_n;
        end
        if (!in_ready) nstall++;
        if (exp_q.size() >= 32) begin
            exp_vld = 1'b1;
            for (int i = 0; i < 32; i++) exp_word[i] = exp_q.pop_front();
        end else begin
            exp_vld = 1'b0;
            exp_word = '0;
        end
        exp_err = 1'b0;
        if (code_q.size() > 0) begin
            in_valid = 1'b1;
            in_len   = code_q[0];
            in_data  = data_q[0];
            if (in_ready) begin
                if (code_q[0] < 3'd5) begin
                    for (int i = 0; i < code_len(code_q[0]); i++) exp_q.push_back(data_q[0][i]);
                end else begin
                    exp_err = 1'b1;
                end
                void'(code_q.pop_front());
                void'(data_q.pop_front());
            end
        end else begin
            in_valid = 1'b0;
            in_len   = '0;
            in_data  = '0;
        end
    endtask

    task automatic offer(input logic [2:0] c, input logic [193:0] d);
        code_q.push_back(c);
        data_q.push_back(d);
    endtask

    task automatic drain();
        while (code_q.size() > 0 || exp_q.size() >= 32) cyc();
        cyc();
        cyc();
    endtask

    task automatic clear_stats();
        nwords = 0; first_v = -1; last_v = -1; nstall = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0; in_len = '0; in_data = '0;
        exp_q.delete(); code_q.delete(); data_q.delete();
        exp_vld = 1'b0; exp_err = 1'b0; exp_word = '0;
        repeat (3) @(negedge clk);
        chk(out_data == 32'd0, "R7 reset out_data", out_data, 0);
        chk(out_valid == 1'b0, "R7 reset out_valid", out_valid, 0);
        chk(len_err == 1'b0, "R7 reset len_err", len_err, 0);
        chk(in_ready == 1'b1, "R7 reset in_ready", in_ready, 1);
        rst_n = 1'b1;
        clear_stats();
    endtask

    task automatic t_normal16();   // R5
        do_reset();
        for (int b = 0; b < 16; b++) offer(3'd2, rnd_blk());
        drain();
        chk(nwords == 65, "R5 word count", nwords, 65);
        chk(last_v - first_v + 1 == 65, "R5 contiguous words", last_v - first_v + 1, 65);
        chk(exp_q.size() == 0, "R5 no leftover", exp_q.size(), 0);
        chk(nstall > 0, "R3 source stalled", nstall, 1);
    endtask

    task automatic t_skip_mix();   // R1 R8
        logic [2:0] seq [10] = '{3'd0, 3'd4, 3'd1, 3'd3, 3'd2, 3'd4, 3'd4, 3'd0, 3'd3, 3'd1};
        int bits = 0;
        do_reset();
        foreach (seq[i]) begin
            offer(seq[i], rnd_blk());
            bits += code_len(seq[i]);
        end
        drain();
        chk(nwords == bits / 32, "R1 R8 words for mixed lengths", nwords, bits / 32);
        chk(exp_q.size() == bits % 32, "R8 residue bits", exp_q.size(), bits % 32);
    endtask

    task automatic t_upper_ignored();   // R2
        logic [193:0] d;
        do_reset();
        d = '1;
        d[65:0] = '0;
        d[1:0] = 2'b10;
        offer(3'd0, d);
        d = '1;
        d[97:0] = '0;
        offer(3'd1, d);
        drain();
        chk(nwords == 5, "R2 words from 164 bits", nwords, 5);
    endtask

    task automatic t_illegal();   // R6
        do_reset();
        offer(3'd2, rnd_blk());
        offer(3'd5, rnd_blk());
        offer(3'd0, rnd_blk());
        offer(3'd7, rnd_blk());
        offer(3'd6, rnd_blk());
        offer(3'd4, rnd_blk());
        drain();
        chk(nwords == (130 + 66 + 194) / 32, "R6 dropped blocks add no bits", nwords, (130 + 66 + 194) / 32);
    endtask

    task automatic t_starve();   // R4
        do_reset();
        offer(3'd0, rnd_blk());
        repeat (6) cyc();
        chk(nwords == 2, "R4 two words from 66 bits", nwords, 2);
        chk(out_valid == 1'b0, "R4 idle while starved", out_valid, 0);
        offer(3'd0, rnd_blk());
        drain();
        chk(nwords == 4, "R4 leftover joined to next block", nwords, 4);
    endtask

    task automatic t_reset_mid();   // R7
        do_reset();
        offer(3'd4, rnd_blk());
        offer(3'd4, rnd_blk());
        repeat (3) cyc();
        do_reset();
        offer(3'd1, rnd_blk());
        drain();
        chk(nwords == 3, "R7 residue cleared by reset", nwords, 3);
    endtask

    initial begin
        #1_500_000;
        n_chk++;
        n_err++;
        $display("FAIL R5 watchdog expired act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0; in_len = '0; in_data = '0;
        cyc_n = 0;
        clear_stats();
        do_reset();
        t_normal16();
        t_skip_mix();
        t_upper_ignored();
        t_illegal();
        t_starve();
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule